// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts every 32-bit virtual address of a processor into one of five architectural segments. It then weighs the segment against the current privilege level and the error-level status bit, and gives one of three answers. The address may be unmapped and turned directly into a physical address with full read and write permission. It may need a lookup in the translation buffer. Or it may be illegal for the current privilege level and be reported as an address error.

The decoder sits in front of the translation buffer in the load/store and fetch path. Its answer comes out of one register stage, so a result is valid one clock after the address and mode are presented. The error-level bit gives firmware a flat view of the low half of the address space: with the bit set, the user segment is identity-mapped and the translation buffer is bypassed.

Top module: `vseg_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is 0 after that edge.
- R2: Privilege encoding: `priv_mode` 2'b10 is user, 2'b01 is supervisor, and 2'b00 and 2'b11 are both kernel.
- R3: An address with bit 31 clear (0x00000000 to 0x7FFFFFFF) is legal in every privilege level. With `err_level`=1 the result is unmapped: `pa_out` equals the virtual address, `rd_ok`=`wr_ok`=1, `tlb_req`=0, `addr_err`=0.
- R4: An address with bit 31 clear and `err_level`=0 gives `tlb_req`=1, `addr_err`=0, `rd_ok`=`wr_ok`=0 and `pa_out`=0, in every privilege level.
- R5: An address in 0x80000000 to 0x9FFFFFFF, in kernel level, is unmapped: `pa_out` = address - 0x80000000, `rd_ok`=`wr_ok`=1, `tlb_req`=0.
- R6: An address in 0xA0000000 to 0xBFFFFFFF, in kernel level, is unmapped: `pa_out` = address - 0xA0000000, `rd_ok`=`wr_ok`=1, `tlb_req`=0.
- R7: An address in 0xC0000000 to 0xDFFFFFFF gives `tlb_req`=1 in supervisor or kernel level.
- R8: An address at 0xE0000000 or above gives `tlb_req`=1 in kernel level only.
- R9: An access that breaks the privilege rules (user level above 0x7FFFFFFF, or supervisor level in 0x80000000 to 0xBFFFFFFF or at 0xE0000000 or above) gives `addr_err`=1 with `tlb_req`, `rd_ok`, `wr_ok` all 0 and `pa_out`=0.
- R10: `err_store` equals `is_write` when `addr_err` is 1 and is 0 otherwise. `is_write` has no other effect on any output.
- R11: `err_level` has no effect on any output for addresses with bit 31 set.
- R12: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr | input | 32 | Virtual address to classify |
| priv_mode | input | 2 | Privilege level (10 user, 01 supervisor, else kernel) |
| err_level | input | 1 | Error-level status bit |
| is_write | input | 1 | 1 for a store, 0 for a load or fetch |
| pa_out | output | 32 | Physical address for unmapped results, else 0 |
| tlb_req | output | 1 | Address must be translated by the TLB |
| addr_err | output | 1 | Privilege violation, address error |
| err_store | output | 1 | The address error came from a store |
| rd_ok | output | 1 | Read permitted on the unmapped result |
| wr_ok | output | 1 | Write permitted on the unmapped result |

## Verification
On every cycle, the assertions check several rules. The three results must exclude each other. A fault must clear the address and the permissions. A user-level access above the low half must always fault. A kernel access to the two direct segments must carry the right offset. The store flag of a fault must follow the previous `is_write`. Only the bench's scenarios can show the rest. Each segment boundary is checked at its first and last address in all four privilege codes, with the error-level bit both set and clear, and with loads and stores. These scenarios also show that the error-level bit is ignored above the low half and that reset clears the outputs.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef enum logic [1:0] {
    PM_KERNEL     = 2'b00,
    PM_SUPER      = 2'b01,
    PM_USER       = 2'b10,
    PM_KERNEL_ALT = 2'b11
  } priv_mode_e;

  typedef enum logic [2:0] {
    SEG_USER     = 3'd0,
    SEG_KDIRECT  = 3'd1,
    SEG_KNOCACHE = 3'd2,
    SEG_SUPMAP   = 3'd3,
    SEG_KMAP     = 3'd4
  } seg_e;

  typedef enum logic [1:0] {
    ACT_FAULT  = 2'd0,
    ACT_DIRECT = 2'd1,
    ACT_TLB    = 2'd2
  } act_e;

endpackage

// File: rtl/vsd_seg_classify.sv
module vsd_seg_classify
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  output seg_e              seg,
  output logic [ADDR_W-1:0] direct_pa
);
  localparam int TOP      = ADDR_W - 1;
  localparam int SEL_W    = 3;
  localparam int OFFSET_W = ADDR_W - SEL_W;

  logic [SEL_W-1:0] sel;
  assign sel = vaddr[TOP -: SEL_W];

  always_comb begin
    seg       = SEG_USER;
    direct_pa = '0;
    if (!sel[SEL_W-1]) begin
      seg       = SEG_USER;
      direct_pa = vaddr;
    end else begin
      unique case (sel[SEL_W-2:0])
        2'b00: begin
          seg       = SEG_KDIRECT;
          direct_pa = {{SEL_W{1'b0}}, vaddr[OFFSET_W-1:0]};
        end
        2'b01: begin
          seg       = SEG_KNOCACHE;
          direct_pa = {{SEL_W{1'b0}}, vaddr[OFFSET_W-1:0]};
        end
        2'b10:   seg = SEG_SUPMAP;
        default: seg = SEG_KMAP;
      endcase
    end
  end
endmodule

// File: rtl/vsd_priv_check.sv
module vsd_priv_check
  import vsd_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] priv_mode,
  input  logic       err_level,
  output act_e       act
);
  logic is_user, is_super, is_kernel;
  assign is_user   = (priv_mode == PM_USER);
  assign is_super  = (priv_mode == PM_SUPER);
  assign is_kernel = !is_user && !is_super;

  always_comb begin
    act = ACT_FAULT;
    unique case (seg)
      SEG_USER:     act = err_level ? ACT_DIRECT : ACT_TLB;
      SEG_KDIRECT,
      SEG_KNOCACHE: act = is_kernel ? ACT_DIRECT : ACT_FAULT;
      SEG_SUPMAP:   act = (is_kernel || is_super) ? ACT_TLB : ACT_FAULT;
      SEG_KMAP:     act = is_kernel ? ACT_TLB : ACT_FAULT;
      default:      act = ACT_FAULT;
    endcase
  end
endmodule

// File: rtl/vsd_out_stage.sv
module vsd_out_stage
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  act_e              act,
  input  logic [ADDR_W-1:0] direct_pa,
  input  logic              is_write,
  output logic [ADDR_W-1:0] pa_out,
  output logic              tlb_req,
  output logic              addr_err,
  output logic              err_store,
  output logic              rd_ok,
  output logic              wr_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pa_out    <= '0;
      tlb_req   <= 1'b0;
      addr_err  <= 1'b0;
      err_store <= 1'b0;
      rd_ok     <= 1'b0;
      wr_ok     <= 1'b0;
    end else begin
      pa_out    <= (act == ACT_DIRECT) ? direct_pa : '0;
      tlb_req   <= (act == ACT_TLB);
      addr_err  <= (act == ACT_FAULT);
      err_store <= (act == ACT_FAULT) && is_write;
      rd_ok     <= (act == ACT_DIRECT);
      wr_ok     <= (act == ACT_DIRECT);
    end
  end

  // R9: one result at a time, fault clears address and permissions
  assert_one_result_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tlb_req, addr_err, rd_ok}));
  assert_fault_clean_R9: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (pa_out == '0 && !rd_ok && !wr_ok));
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        priv_mode,
  input  logic              err_level,
  input  logic              is_write,
  output logic [ADDR_W-1:0] pa_out,
  output logic              tlb_req,
  output logic              addr_err,
  output logic              err_store,
  output logic              rd_ok,
  output logic              wr_ok
);
  localparam int TOP = ADDR_W - 1;

  seg_e              seg;
  act_e              act;
  logic [ADDR_W-1:0] direct_pa;

  vsd_seg_classify #(.ADDR_W(ADDR_W)) u_classify (
    .vaddr     (vaddr),
    .seg       (seg),
    .direct_pa (direct_pa)
  );

  vsd_priv_check u_priv (
    .seg       (seg),
    .priv_mode (priv_mode),
    .err_level (err_level),
    .act       (act)
  );

  vsd_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .direct_pa (direct_pa),
    .is_write  (is_write),
    .pa_out    (pa_out),
    .tlb_req   (tlb_req),
    .addr_err  (addr_err),
    .err_store (err_store),
    .rd_ok     (rd_ok),
    .wr_ok     (wr_ok)
  );

  // R9: user level above the low half always faults
  assert_user_high_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(priv_mode) == PM_USER && $past(vaddr[TOP])) |-> addr_err);

  // R5 / R6: kernel access to the direct segments keeps the low offset
  assert_kernel_direct_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(priv_mode) == PM_KERNEL || $past(priv_mode) == PM_KERNEL_ALT)
     && $past(vaddr[TOP -: 2]) == 2'b10)
    |-> (rd_ok && pa_out[TOP -: 3] == 3'b000 && pa_out[TOP-3:0] == $past(vaddr[TOP-3:0])));

  // R10: store flag of a fault follows the previous write flag
  assert_err_store_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && addr_err) |-> (err_store == $past(is_write)));
  assert_no_store_flag_R10: assert property (@(posedge clk) disable iff (rst)
    !addr_err |-> !err_store);
endmodule

// File: tb/tb_vseg_decoder.sv
module tb_vseg_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] vaddr = 32'h0;
  logic [1:0]  priv_mode = 2'b00;
  logic        err_level = 1'b0;
  logic        is_write = 1'b0;
  logic [31:0] pa_out;
  logic        tlb_req, addr_err, err_store, rd_ok, wr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vseg_decoder dut (
    .clk(clk), .rst(rst), .vaddr(vaddr), .priv_mode(priv_mode),
    .err_level(err_level), .is_write(is_write), .pa_out(pa_out),
    .tlb_req(tlb_req), .addr_err(addr_err), .err_store(err_store),
    .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  // packed expectation: {pa, tlb, err, store, rd, wr}
  function automatic logic [36:0] model(input logic [31:0] a, input logic [1:0] m,
                                        input logic erl, input logic wr,
                                        output string tag);
    longint ua = longint'(a);
    bit user  = (m == 2'b10);
    bit sup   = (m == 2'b01);
    bit kern  = !user && !sup;
    logic [31:0] pa = 32'h0;
    bit tlb = 0, bad = 0, ok = 0;
    if (ua < 64'h8000_0000) begin
      if (erl) begin pa = a; ok = 1; tag = "R3"; end
      else begin tlb = 1; tag = "R4"; end
    end else if (ua < 64'hA000_0000) begin
      if (kern) begin pa = a - 32'h8000_0000; ok = 1; tag = "R5"; end
      else begin bad = 1; tag = "R9"; end
    end else if (ua < 64'hC000_0000) begin
      if (kern) begin pa = a - 32'hA000_0000; ok = 1; tag = "R6"; end
      else begin bad = 1; tag = "R9"; end
    end else if (ua < 64'hE000_0000) begin
      if (kern || sup) begin tlb = 1; tag = "R7"; end
      else begin bad = 1; tag = "R9"; end
    end else begin
      if (kern) begin tlb = 1; tag = "R8"; end
      else begin bad = 1; tag = "R9"; end
    end
    if (bad && wr) tag = "R10";
    return {pa, tlb, bad, bad && wr, ok, ok};
  endfunction

  task automatic compare(input logic [36:0] exp, input string tag);
    logic [36:0] act = {pa_out, tlb_req, addr_err, err_store, rd_ok, wr_ok};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got pa=%h tlb/err/st/rd/wr=%b expected pa=%h %b",
               tag, act[36:5], act[4:0], exp[36:5], exp[4:0]);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] m,
                       input logic erl, input logic wr, input string note);
    string tag;
    logic [36:0] exp;
    @(negedge clk);
    vaddr = a; priv_mode = m; err_level = erl; is_write = wr;
    exp = model(a, m, erl, wr, tag);
    @(posedge clk);
    #1;
    // R12: result visible one edge after the inputs; R2 mode codes, R11 ERL ignored high
    compare(exp, {tag, note});
  endtask

  initial begin
    logic [31:0] pts [12];
    pts = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
            32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
            32'hE000_0000, 32'hFFFF_FFFF, 32'h8123_4567, 32'hA765_4321};
    // R1: reset clears outputs even with active inputs
    vaddr = 32'h8000_1234; priv_mode = 2'b00; err_level = 1'b1; is_write = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    compare(37'h0, "R1");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 12; i++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int w = 0; w < 2; w++)
            apply(pts[i], 2'(m), 1'(e), 1'(w), (m == 3) ? " R2" : ((pts[i][31] && e == 1) ? " R11" : ""));
    // R12: back-to-back changes every cycle
    apply(32'h1234_5678, 2'b10, 1'b1, 1'b0, " R12");
    apply(32'hF000_0000, 2'b10, 1'b1, 1'b1, " R12");
    apply(32'h9000_0000, 2'b11, 1'b0, 1'b0, " R12");
    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    compare(37'h0, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule